// File: doc/BRIEF.md
# Pairwise Tree Reduction Sequencer

This block adds a fixed number of partial sums into one total. A start pulse captures all operands at once from a parallel load bus into a small register array. The block then works through a series of rounds, one per clock cycle. In each round the live range of the array is cut in half, and every entry in the lower half takes in its partner from the upper half. An odd live count is handled by adding the last live entry into entry 0 in the same round. Because of this, the operand count does not need to be a power of two.

A host loads the operands and pulses start. It then waits for the one-cycle done pulse and reads the total from the result output. The total stays there until the next accepted start. Additions wrap modulo 2^DATA_W. The number of rounds is floor(log2(N_ENTRIES)).

Top module: `tree_red_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, busy_o and done_o are 0 and sum_o is 0.
- R2: When start_i is high at a clock edge while busy_o is low, the block captures load_data_i and busy_o is 1 after that edge. Entry p is taken from bits [p*DATA_W +: DATA_W].
- R3: start_i is ignored while busy_o is high. A start pulse during a reduction, with different load data, changes neither the final total nor the number of rounds.
- R4: Each busy cycle performs one round, and the live count halves with integer division. busy_o stays high for exactly floor(log2(N_ENTRIES)) cycles: 1 for N=2 and N=3, 3 for N=10, and 4 for N=16.
- R5: When the live count is odd at the start of a round, entry 0 also takes in entry [count-1] in that same round. The fold and the pair additions use the values from before the round, so odd counts such as 3 and 10 give the exact total.
- R6: When done_o is high, sum_o equals the sum of all N_ENTRIES captured operands modulo 2^DATA_W.
- R7: done_o is high for exactly one cycle. That cycle is the first cycle in which busy_o is low after a reduction.
- R8: While busy_o is low and no start is accepted, sum_o holds its value even if load_data_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; captures the operands when idle |
| load_data_i | input | N_ENTRIES*DATA_W | Operands, with entry p in bits [p*DATA_W +: DATA_W] |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse when the total is ready |
| sum_o | output | DATA_W | Entry 0; holds the total after done_o |

## Verification
The bench builds four copies of the block side by side, each with DATA_W=16. They use N_ENTRIES of 2, 3, 10 and 16, and all four are driven by the same operand bus. N=2 covers the single even round, and N=3 covers a fold that lands in the only round. N=10 takes the 10, 5, 2, 1 path, with a fold in the middle round. N=16 covers the deepest all-even tree and, with all-ones operands, wraps the total. The expected totals come from a plain sequential sum taken over each copy's share of the bus.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tree_red_ctrl.sv
module tree_red_ctrl #(
  parameter int N_ENTRIES = 10,
  localparam int CNT_W = tree_red_pkg::cnt_bits(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             round_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] half_o,
  output logic             odd_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [CNT_W-1:0] half;

  assign half    = cnt_q >> 1;
  assign load_o  = start_i && !busy_q;
  assign round_o = busy_q;
  assign cnt_o   = cnt_q;
  assign half_o  = half;
  assign odd_o   = cnt_q[0];
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        cnt_q  <= CNT_W'(N_ENTRIES);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= half;
        if (half == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q >= CNT_W'(2) && cnt_q <= CNT_W'(N_ENTRIES))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R7
endmodule

// File: rtl/tree_red_datapath.sv
module tree_red_datapath #(
  parameter int N_ENTRIES = 10,
  parameter int DATA_W    = 16,
  localparam int CNT_W = tree_red_pkg::cnt_bits(N_ENTRIES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        round_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [CNT_W-1:0]            half_i,
  input  logic                        odd_i,
  input  logic [N_ENTRIES*DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0]           sum_o
);
  logic [N_ENTRIES*DATA_W-1:0] ent_flat;

  for (genvar p = 0; p < N_ENTRIES; p++) begin : g_lane
    logic [DATA_W-1:0] ent_q, partner, fold, nxt;

    // partner sits half_i above; lane 0 also folds the last live entry on odd counts
    always_comb begin
      partner = '0;
      fold    = '0;
      for (int j = 0; j < N_ENTRIES; j++) begin
        if (j == p + int'(half_i)) partner = ent_flat[j*DATA_W +: DATA_W];
        if (p == 0 && odd_i && j == int'(cnt_i) - 1) fold = ent_flat[j*DATA_W +: DATA_W];
      end
      nxt = (p < int'(half_i)) ? ent_q + partner + fold : ent_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q <= '0;
      else if (load_i)  ent_q <= load_data_i[p*DATA_W +: DATA_W];
      else if (round_i) ent_q <= nxt;
    end

    assign ent_flat[p*DATA_W +: DATA_W] = ent_q;
  end

  assign sum_o = ent_flat[DATA_W-1:0];

  AST_LOAD_ROUND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && round_i)); // R3
endmodule

// File: rtl/tree_red_seq.sv
module tree_red_seq #(
  parameter int N_ENTRIES = 10,
  parameter int DATA_W    = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [N_ENTRIES*DATA_W-1:0] load_data_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [DATA_W-1:0]           sum_o
);
  localparam int CNT_W = tree_red_pkg::cnt_bits(N_ENTRIES);

  logic             load, round, odd;
  logic [CNT_W-1:0] cnt, half;

  tree_red_ctrl #(.N_ENTRIES(N_ENTRIES)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .round_o (round),
    .cnt_o   (cnt),
    .half_o  (half),
    .odd_o   (odd),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  tree_red_datapath #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) i_datapath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .round_i     (round),
    .cnt_i       (cnt),
    .half_i      (half),
    .odd_i       (odd),
    .load_data_i (load_data_i),
    .sum_o       (sum_o)
  );

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sum_o)); // R8
endmodule

// File: tb/test_tree_red_seq.sv
`timescale 1ns/1ps
module test_tree_red_seq;
  localparam int W = 16;
  localparam int ND = 4;
  localparam int NS [ND] = '{2, 3, 10, 16};
  localparam int NPAT = 8;
  localparam logic [W-1:0] SEED_TAB [NPAT] = '{16'h0001, 16'h1234, 16'hBEEF, 16'h7FFF,
                                               16'h00FF, 16'hA5A5, 16'hFFFF, 16'h3C71};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [16*W-1:0] load_data = '0;
  logic busy_w [ND];
  logic done_w [ND];
  logic [W-1:0] sum_w [ND];
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < ND; g++) begin : g_dut
    logic [W-1:0] s;
    logic b, d;
    tree_red_seq #(.N_ENTRIES(NS[g]), .DATA_W(W)) i_tree_red_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .load_data_i(load_data[NS[g]*W-1:0]),
      .busy_o(b), .done_o(d), .sum_o(s));
    assign busy_w[g] = b;
    assign done_w[g] = d;
    assign sum_w[g]  = s;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_sum(input int n, input logic [16*W-1:0] d);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < n; i++) acc = acc + d[i*W +: W];
    return acc;
  endfunction

  function automatic int ref_rounds(input int n);
    int r = 0;
    while (n > 1) begin
      n = n / 2;
      r++;
    end
    return r;
  endfunction

  function automatic logic [16*W-1:0] make_data(input logic [W-1:0] seed);
    logic [16*W-1:0] d;
    for (int i = 0; i < 16; i++) d[i*W +: W] = W'(seed * W'(i + 1) + W'(16'h0713 * i));
    return d;
  endfunction

  task automatic run_case(input logic [16*W-1:0] da, input bit overlap, input logic [16*W-1:0] db);
    int lat [ND];
    logic [W-1:0] res [ND];
    bit seen_prev [ND];
    @(negedge clk);
    load_data = da;
    start = 1'b1;
    @(negedge clk);
    for (int g = 0; g < ND; g++) chk(busy_w[g] == 1'b1, "R2 busy after start", int'(busy_w[g]), 1);
    if (overlap) load_data = db;
    else start = 1'b0;
    for (int g = 0; g < ND; g++) begin
      lat[g] = -1;
      res[g] = '0;
      seen_prev[g] = 1'b0;
    end
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      start = 1'b0;
      for (int g = 0; g < ND; g++) begin
        if (seen_prev[g]) chk(done_w[g] == 1'b0, "R7 done single cycle", int'(done_w[g]), 0);
        seen_prev[g] = 1'b0;
        if (done_w[g] && lat[g] < 0) begin
          lat[g] = k;
          res[g] = sum_w[g];
          seen_prev[g] = 1'b1;
          chk(busy_w[g] == 1'b0, "R7 busy low with done", int'(busy_w[g]), 0);
        end
      end
    end
    for (int g = 0; g < ND; g++) begin
      chk(lat[g] == ref_rounds(NS[g]), overlap ? "R3 R4 round count" : "R4 round count",
          lat[g], ref_rounds(NS[g]));
      chk(res[g] == ref_sum(NS[g], da),
          overlap ? "R3 total unaffected" : ((NS[g] % 2 == 1 || NS[g] == 10) ? "R5 R6 total" : "R6 total"),
          int'(res[g]), int'(ref_sum(NS[g], da)));
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] held [ND];
    repeat (3) @(negedge clk);
    for (int g = 0; g < ND; g++) begin
      chk(busy_w[g] == 1'b0 && done_w[g] == 1'b0, "R1 reset flags", int'({busy_w[g], done_w[g]}), 0);
      chk(sum_w[g] == '0, "R1 reset sum", int'(sum_w[g]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < ND; g++)
      chk(busy_w[g] == 1'b0 && done_w[g] == 1'b0 && sum_w[g] == '0, "R1 after release",
          int'(sum_w[g]), 0);

    for (int t = 0; t < NPAT; t++) run_case(make_data(SEED_TAB[t]), 1'b0, '0);

    // wrap: all ones
    run_case({16{16'hFFFF}}, 1'b0, '0);

    // start during reduction with different data
    run_case(make_data(16'h4242), 1'b1, make_data(16'h9999));

    // idle hold with changing operands
    for (int g = 0; g < ND; g++) held[g] = sum_w[g];
    load_data = make_data(16'h5555);
    repeat (4) @(negedge clk);
    for (int g = 0; g < ND; g++) begin
      chk(sum_w[g] == held[g], "R8 idle hold", int'(sum_w[g]), int'(held[g]));
      chk(busy_w[g] == 1'b0, "R8 stays idle", int'(busy_w[g]), 0);
    end

    // back-to-back case after idle
    run_case(make_data(16'h0F0F), 1'b0, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule